// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two independent 32-bit down-counters behind a small register bus. Software sets them up through one shared control word. Each counter can be switched on or off and can be set to reload itself on expiry. Each also picks its count source: an external reference tick, or the bus clock divided by a power of two. Each counter raises an event flag when it runs out. That flag drives the counter's own interrupt line and stays set until software clears it by writing a zero to the flag's bit.

There are three typical uses. A counter loaded with all ones and set to reload becomes a free-running timebase, and software reads elapsed time as the bitwise inverse of the count. A counter with reload enabled gives periodic interrupts when its reload register holds the period minus one. A counter with reload disabled gives a single delayed interrupt after a value is written into it.

The bus is single-cycle. A write takes effect at the clock edge that samples it. Read data is combinational from the selected register and valid in the same cycle.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register reads zero and both interrupt lines are low.
- R2: The control word keeps only its defined fields, and every other bit reads zero:
  - bit 0: timer 0 enable; bit 1: timer 0 reload enable.
  - bit 2: timer 1 enable; bit 3: timer 1 reload enable.
  - bit 11: timer 0 reference-tick select; bit 12: timer 1 reference-tick select.
  - bits 21:19: timer 0 prescale exponent; bits 24:22: timer 1 prescale exponent.
  - Writing all ones therefore reads back 0x01F8180F.
- R3: The register offsets are: control 0x00, status 0x04, timer 0 reload 0x10, timer 0 value 0x14, timer 1 reload 0x18, timer 1 value 0x1C. Writing a value register loads the live count at once. An enabled counter then decrements by one on each tick of its selected source.
- R4: With reload enabled and a reload value N, an event occurs on the tick that finds the count at zero, and at that same tick the count becomes N. Events therefore repeat every N+1 ticks.
- R5: With reload disabled, a counter loaded with V raises its event on tick V+1 and then stays at zero. It raises no further event until its value register is written again.
- R6: When the reference-select bit is clear, the counter ticks once every 2^n bus clock cycles, where n is the prescale exponent.
- R7: Clearing a counter's enable bit freezes its count at once, and its pending event flag is kept.
- R8: The status register shows timer 0's flag at bit 0 and timer 1's flag at bit 8. Writing 0 to a flag bit clears that flag, and writing 1 to it leaves the flag unchanged.
- R9: Each interrupt output (irq[0] for timer 0, irq[1] for timer 1) equals that timer's event flag and stays high until the flag is cleared.
- R10: The two timers are independent. Writing or ticking one timer does not change the other's registers or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick enable, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 2 | Interrupt line per timer (bit 0 = timer 0) |

## Verification
The bench drives the reference tick by hand, so each count step can be placed at a known edge. It checks the exact tick on which a one-shot counter expires. A design that fired on reaching zero instead of on leaving it would flag one tick early. The bench then keeps ticking a spent one-shot counter and expects silence, which exposes a counter that wraps or fires again. It measures the cycle distance between prescaled events, where a wrong divide tap would change the period by a power of two. It also writes all-ones to the status register while a flag is pending, which catches a write-one-to-clear mix-up.

// File: rtl/timer_pkg.sv
// Shared constants for the dual down-counting timer: widths, register
// offsets and the bit positions of the control and status fields.
// Assumes exactly two timers; the field layout is fixed by software.
package timer_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int PRE_W   = 3;
    localparam int NUM_TMR = 2;
    localparam int NUM_DIV = 2 ** PRE_W;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h04;

    // Reload register offset of timer i
    function automatic logic [ADDR_W-1:0] rld_off(input int i);
        return ADDR_W'(8'h10 + 8 * i);
    endfunction

    // Live count register offset of timer i
    function automatic logic [ADDR_W-1:0] val_off(input int i);
        return ADDR_W'(8'h14 + 8 * i);
    endfunction

    function automatic int en_bit(input int i);
        return 2 * i;
    endfunction

    function automatic int rl_bit(input int i);
        return 2 * i + 1;
    endfunction

    function automatic int ref_bit(input int i);
        return 11 + i;
    endfunction

    function automatic int div_lsb(input int i);
        return 19 + PRE_W * i;
    endfunction

    function automatic int flag_bit(input int i);
        return 8 * i;
    endfunction

    // Mask of all implemented control bits
    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            m[en_bit(i)]  = 1'b1;
            m[rl_bit(i)]  = 1'b1;
            m[ref_bit(i)] = 1'b1;
            for (int b = 0; b < PRE_W; b++) begin
                m[div_lsb(i) + b] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running divider shared by all timers. It emits one strobe per
// division setting: strobe[k] pulses once every 2^k clock cycles
// (strobe[0] is high on every cycle). Assumes nothing about its consumers.
module tmr_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [2**PRE_W-1:0]   strobe
);
    localparam int NDIV  = 2 ** PRE_W;
    localparam int CNT_W = NDIV - 1;

    logic [CNT_W-1:0] cnt_q;

    // Count every cycle; the low bits form the division taps
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Tap k fires when the low k bits are all ones
    genvar k;
    generate
        for (k = 0; k < NDIV; k++) begin : g_tap
            if (k == 0) begin : g_every
                assign strobe[k] = 1'b1;
            end else begin : g_div
                assign strobe[k] = &cnt_q[k-1:0];
            end
        end
    endgenerate

    // R6: the divider advances by one each cycle
    a_r6_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

    // R6: a divide-by-two tap never fires on two cycles in a row
    a_r6_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[1] |=> !strobe[1]);
endmodule

// File: rtl/tmr_channel.sv
// One down-counter with its reload register and event flag.
// It counts on tick while enabled. On a tick that finds the count at zero
// it raises the flag, and then either reloads or, when reload is off,
// disarms until the value register is written again.
// Assumes tick is a one-cycle strobe; a value write wins over a tick.
module tmr_channel #(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          reload_en,
    input  logic          rld_wr,
    input  logic          val_wr,
    input  logic [W-1:0]  wdata,
    input  logic          flag_clr,
    output logic [W-1:0]  reload,
    output logic [W-1:0]  value,
    output logic          flag
);
    logic armed_q;
    logic step;
    logic at_zero;
    logic fire;

    // Decode this cycle's count action
    always_comb begin
        step    = tick && enable && !val_wr;
        at_zero = (value == '0);
        fire    = step && at_zero && (reload_en || armed_q);
    end

    // Reload register: plain write
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (rld_wr) reload <= wdata;
    end

    // Live count and one-shot arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value   <= '0;
            armed_q <= 1'b0;
        end else if (val_wr) begin
            value   <= wdata;
            armed_q <= 1'b1;
        end else if (step) begin
            if (!at_zero)       value   <= value - 1'b1;
            else if (reload_en) value   <= reload;
            else                armed_q <= 1'b0;
        end
    end

    // Event flag: set on expiry, cleared by request, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= fire || (flag && !flag_clr);
    end

    // R7: a disabled counter holds its count
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !val_wr |=> value == $past(value));

    // R3: a tick on a non-zero count decrements by one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        tick && enable && !val_wr && value != '0 |=> value == $past(value) - 1'b1);

    // R4: a tick at zero with reload on loads the reload value and flags
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick && enable && !val_wr && value == '0 && reload_en
        |=> value == $past(reload) && flag);

    // R5: a spent one-shot counter raises no new flag
    a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q && !reload_en && !val_wr && !flag |=> !flag);

    // R8: a pending flag survives any cycle without a clear request
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !flag_clr |=> flag);
endmodule

// File: rtl/dual_down_timer.sv
// Top of the dual down-counting timer: register decode, shared control
// word, status flags with write-zero-to-clear, tick source selection and
// one interrupt line per timer. Assumes a single-cycle bus in which a
// write takes effect at the sampling edge and reads are combinational.
module dual_down_timer
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq
);
    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_DIV-1:0] pre_strobe;
    logic               wr_ctrl;
    logic               wr_stat;
    logic [DATA_W-1:0]  rld_val [NUM_TMR];
    logic [DATA_W-1:0]  cnt_val [NUM_TMR];
    logic [NUM_TMR-1:0] flags;

    // Write strobes for the shared registers
    always_comb begin
        wr_ctrl = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
        wr_stat = bus_sel && bus_wr && (bus_addr == OFF_STAT);
    end

    // Control word keeps only implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (pre_strobe)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_TMR; i++) begin : g_tmr
            logic [PRE_W-1:0] div_sel;
            logic             tick_sel;

            // Pick the reference tick or the prescaled strobe
            always_comb begin
                div_sel  = ctrl_q[div_lsb(i) +: PRE_W];
                tick_sel = ctrl_q[ref_bit(i)] ? ref_tick : pre_strobe[div_sel];
            end

            tmr_channel #(.W(DATA_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick_sel),
                .enable    (ctrl_q[en_bit(i)]),
                .reload_en (ctrl_q[rl_bit(i)]),
                .rld_wr    (bus_sel && bus_wr && bus_addr == rld_off(i)),
                .val_wr    (bus_sel && bus_wr && bus_addr == val_off(i)),
                .wdata     (bus_wdata),
                .flag_clr  (wr_stat && !bus_wdata[flag_bit(i)]),
                .reload    (rld_val[i]),
                .value     (cnt_val[i]),
                .flag      (flags[i])
            );

            assign irq[i] = flags[i];
        end
    endgenerate

    // Read mux over all registers
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_CTRL) bus_rdata = ctrl_q;
        if (bus_addr == OFF_STAT) begin
            for (int t = 0; t < NUM_TMR; t++) bus_rdata[flag_bit(t)] = flags[t];
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            if (bus_addr == rld_off(t)) bus_rdata = rld_val[t];
            if (bus_addr == val_off(t)) bus_rdata = cnt_val[t];
        end
    end

    // R10: a value write to timer 0 leaves timer 1's count alone while it is off
    a_r10_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == val_off(0) && !ctrl_q[en_bit(1)]
        |=> cnt_val[1] == $past(cnt_val[1]));

    // R2: a control write keeps exactly the implemented bits
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl_q == ($past(bus_wdata) & CTRL_MASK));
endmodule

// File: tb/dual_down_timer_bench.sv
// Scoreboard bench: read tasks push expected words into a queue and a
// monitor pops and compares them against bus_rdata mid-cycle.
module dual_down_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int          n_checks = 0;
    int          n_fails = 0;
    int          cyc = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mon_exp;
    string       mon_tag;

    localparam logic [31:0] EN0 = 32'h1, RL0 = 32'h2, EN1 = 32'h4, RL1 = 32'h8;
    localparam logic [31:0] RF0 = 32'h800, RF1 = 32'h1000;

    dual_down_timer u_dual_down_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read against the head of the scoreboard
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            check(bus_rdata, mon_exp, mon_tag);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1 ref_tick = 1'b1;
            @(posedge clk); #1 ref_tick = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        @(negedge clk);
        check({30'd0, irq}, {30'd0, e}, tag);
    endtask

    task automatic wait_irq(input int idx);
        @(negedge clk);
        while (!irq[idx]) @(negedge clk);
    endtask

    // Measure cycles between two consecutive events of one timer
    task automatic measure(input int idx, input int exp_cyc, input string tag);
        int t1;
        int t2;
        logic [31:0] clr;
        clr = ~(32'h1 << (8 * idx));
        wait_irq(idx);
        wr(6'h04, clr);
        wait_irq(idx); t1 = cyc;
        wr(6'h04, clr);
        wait_irq(idx); t2 = cyc;
        check(32'(t2 - t1), 32'(exp_cyc), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++; n_checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, 0, "R1 ctrl");
        rd(6'h04, 0, "R1 status");
        rd(6'h10, 0, "R1 rld0");
        rd(6'h14, 0, "R1 val0");
        rd(6'h18, 0, "R1 rld1");
        rd(6'h1C, 0, "R1 val1");
        chk_irq(2'b00, "R1 irq");

        // R2 control field mask
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, 32'h01F8180F, "R2 ctrl mask");
        wr(6'h00, 0);

        // R3 load and decrement with reference ticks
        wr(6'h14, 5); wr(6'h10, 100);
        wr(6'h00, EN0 | RF0);
        rd(6'h14, 5, "R3 load");
        ticks(2);
        rd(6'h14, 3, "R3 decrement");
        rd(6'h1C, 0, "R10 timer1 untouched");

        // R5 one-shot
        ticks(3);
        rd(6'h14, 0, "R5 reaches zero");
        rd(6'h04, 0, "R5 no flag at zero");
        ticks(1);
        rd(6'h04, 32'h1, "R5 flag on leaving zero");
        chk_irq(2'b01, "R9 irq0 follows flag");
        ticks(2);
        rd(6'h14, 0, "R5 holds zero");
        wr(6'h04, 32'hFFFF_FFFE);
        rd(6'h04, 0, "R8 write zero clears");
        chk_irq(2'b00, "R9 irq0 drops");
        ticks(3);
        rd(6'h04, 0, "R5 no retrigger");
        wr(6'h14, 1);
        ticks(1);
        rd(6'h04, 0, "R5 rearm pending");
        ticks(1);
        rd(6'h04, 32'h1, "R5 rearmed fires");
        wr(6'h04, 32'hFFFF_FFFE);

        // R4 periodic reload
        wr(6'h10, 2); wr(6'h14, 2);
        wr(6'h00, EN0 | RL0 | RF0);
        ticks(2);
        rd(6'h04, 0, "R4 no early event");
        ticks(1);
        rd(6'h04, 32'h1, "R4 event at period");
        rd(6'h14, 2, "R4 reloaded");
        wr(6'h04, 32'hFFFF_FFFE);
        ticks(2);
        rd(6'h04, 0, "R4 second period early");
        ticks(1);
        rd(6'h04, 32'h1, "R4 second event");

        // R8 write-one keeps flag, timer 1 at bit 8
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, 32'h1, "R8 write one keeps");
        wr(6'h00, EN1 | RF1 | RF0);
        wr(6'h1C, 0);
        ticks(1);
        rd(6'h04, 32'h101, "R8 timer1 flag bit 8");
        chk_irq(2'b11, "R9 both irq");
        wr(6'h04, 32'hFFFF_FEFF);
        rd(6'h04, 32'h1, "R8 clear only timer1");
        rd(6'h14, 2, "R10 timer0 count kept");
        wr(6'h04, 32'hFFFF_FFFE);

        // R7 freeze on disable, flag kept
        wr(6'h00, EN0 | EN1 | RF0 | RF1);
        wr(6'h14, 10); wr(6'h1C, 0);
        ticks(2);
        rd(6'h14, 8, "R7 counting");
        rd(6'h04, 32'h100, "R7 flag set");
        wr(6'h00, RF0 | RF1);
        ticks(3);
        rd(6'h14, 8, "R7 frozen count");
        rd(6'h04, 32'h100, "R7 flag kept");
        chk_irq(2'b10, "R9 irq1 held");
        wr(6'h04, 32'hFFFF_FEFE);

        // R6 prescaled periods
        wr(6'h10, 3); wr(6'h14, 3);
        wr(6'h00, EN0 | RL0 | (32'd2 << 19));
        measure(0, 16, "R6 div4 reload3");
        wr(6'h10, 1);
        wr(6'h00, EN0 | RL0 | (32'd5 << 19));
        measure(0, 64, "R6 div32 reload1");
        wr(6'h18, 0);
        wr(6'h00, EN1 | RL1 | (32'd3 << 22));
        measure(1, 8, "R6 timer1 div8");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule